// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache placed between a CPU that reads and writes single bytes and a main memory that moves whole 4-byte blocks. Each 24-bit byte address is split into a tag, a set index and a byte offset. The set index selects one of 8192 sets, and each set holds two lines. The tag is compared against both lines of the selected set. A hit is served from the cache. A miss first brings the block in from memory and then completes the access.

Replacement uses one least-recently-used bit per set. Writes stay in the cache and mark the line dirty. A line goes back to memory only when it is evicted while dirty. A write miss allocates the line: the block is fetched, the byte is merged into it and the line is marked dirty.

The CPU holds its request until a one-cycle completion pulse. The memory side holds its request until the memory acknowledges it.

Top module: `wsa_cache`

## Requirements
- R1: The address is split as tag = addr[23:15] (9 bits), set = addr[14:2] (13 bits) and byte offset = addr[1:0]. The memory block address is addr[23:2], which is {tag, set}.
- R2: A read hit returns the addressed byte and makes no memory transfer. Byte offset k of a block is block bits [8k+7:8k].
- R3: A read miss makes exactly one memory read of the block, installs the block and returns the addressed byte from it.
- R4: A write hit updates only the cached byte and makes no memory transfer. The line becomes dirty.
- R5: A write miss reads the block once, merges the written byte into it and marks the line dirty. It makes no memory write for the written byte itself.
- R6: On a miss, an invalid way is filled before any valid way is evicted. Way 0 is preferred when both ways are invalid.
- R7: When both ways are valid, the victim is the way not used most recently. Every hit and every fill counts as a use. After reset, the LRU bit of every set selects way 0.
- R8: A dirty victim is first written to memory as one 4-byte write to block {victim tag, set}, and the fill read follows. A clean victim causes no memory write.
- R9: Reset clears every valid bit. Dirty data is discarded without a write-back, and the first access afterwards misses.
- R10: cpu_done is high for exactly one cycle per request. A memory request keeps mem_req, mem_we and mem_addr unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid; held until cpu_done |
| cpu_we | input | 1 | 1 = write byte, 0 = read byte |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with cpu_done |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back of a block, 0 = block read |
| mem_addr | output | 22 | Block address |
| mem_wdata | output | 32 | Block written back |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 32 | Block read, valid with mem_ack |

## Verification
The hardest situation to reach is an eviction whose victim depends on LRU history and whose dirty state must cause a write-back. A later miss must then read the written-back byte from memory. The stimulus drives three and then four distinct tags into one set, with reads and writes interleaved so that the LRU bit points at a dirty way at one eviction and at a clean way at the next. Afterwards it re-reads an evicted block to confirm what was written back. A second set shows that sets are independent, and a final reset shows that dirty data is discarded.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
    localparam int TAG_W  = 9;
    localparam int SET_W  = 13;
    localparam int OFF_W  = 2;
    localparam int BYTE_W = 8;
    localparam int LINE_W = BYTE_W << OFF_W;
    localparam int ADDR_W = TAG_W + SET_W + OFF_W;
    localparam int BLK_W  = TAG_W + SET_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_DONE
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e           state;
        logic [ADDR_W-1:0]    addr;
        logic                 we;
        logic [BYTE_W-1:0]    wdata;
        logic                 victim;
        logic [BYTE_W-1:0]    rdata;
    } ctl_regs_t;
endpackage

// File: rtl/wsa_way_store.sv
module wsa_way_store #(
    parameter int TAG_W  = 9,
    parameter int SET_W  = 13,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_dirty,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              wr_dirty
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] data_mem [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;

    assign rd_tag   = tag_mem[rd_set];
    assign rd_data  = data_mem[rd_set];
    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[rd_set]  <= wr_tag;
            data_mem[rd_set] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[rd_set] <= 1'b1;
            dirty_q[rd_set] <= wr_dirty;
        end
    end
endmodule

// File: rtl/wsa_lookup.sv
module wsa_lookup #(
    parameter int TAG_W = 9
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] way_tag [2],
    input  logic [1:0]       way_valid,
    input  logic             lru,
    output logic             hit,
    output logic             hit_way,
    output logic             victim
);
    logic [1:0] match;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit     = |match;
    assign hit_way = match[1];

    // Invalid ways are filled first, way 0 before way 1; otherwise the LRU way.
    always_comb begin
        if (!way_valid[0])      victim = 1'b0;
        else if (!way_valid[1]) victim = 1'b1;
        else                    victim = lru;
    end
endmodule

// File: rtl/wsa_cache.sv
module wsa_cache
    import wsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BLK_W-1:0]  mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    localparam int SETS = 1 << SET_W;

    ctl_regs_t r_q, r_d;
    logic [SETS-1:0] lru_q;
    logic            lru_we;
    logic            lru_val;

    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  look_tag;
    logic [SET_W-1:0]  look_set;
    logic [OFF_W-1:0]  look_off;

    logic [TAG_W-1:0]  way_tag   [2];
    logic [LINE_W-1:0] way_data  [2];
    logic [1:0]        way_valid;
    logic [1:0]        way_dirty;
    logic [1:0]        wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [LINE_W-1:0] wr_data;
    logic              wr_dirty;
    logic              hit, hit_way, victim;

    assign look_addr = (r_q.state == ST_IDLE) ? cpu_addr : r_q.addr;
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
    assign look_set  = look_addr[OFF_W +: SET_W];
    assign look_off  = look_addr[OFF_W-1:0];

    for (genvar w = 0; w < 2; w++) begin : g_way
        wsa_way_store #(.TAG_W(TAG_W), .SET_W(SET_W), .LINE_W(LINE_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_set   (look_set),
            .rd_tag   (way_tag[w]),
            .rd_data  (way_data[w]),
            .rd_valid (way_valid[w]),
            .rd_dirty (way_dirty[w]),
            .wr_en    (wr_en[w]),
            .wr_tag   (wr_tag),
            .wr_data  (wr_data),
            .wr_dirty (wr_dirty)
        );
    end

    wsa_lookup #(.TAG_W(TAG_W)) u_lookup (
        .req_tag   (look_tag),
        .way_tag   (way_tag),
        .way_valid (way_valid),
        .lru       (lru_q[look_set]),
        .hit       (hit),
        .hit_way   (hit_way),
        .victim    (victim)
    );

    function automatic logic [LINE_W-1:0] merge_byte(
        input logic [LINE_W-1:0] line, input logic [OFF_W-1:0] off, input logic [BYTE_W-1:0] b);
        logic [LINE_W-1:0] res;
        res = line;
        res[off*BYTE_W +: BYTE_W] = b;
        return res;
    endfunction

    always_comb begin
        r_d      = r_q;
        wr_en    = '0;
        wr_tag   = look_tag;
        wr_data  = '0;
        wr_dirty = 1'b0;
        lru_we   = 1'b0;
        lru_val  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    r_d.addr  = cpu_addr;
                    r_d.we    = cpu_we;
                    r_d.wdata = cpu_wdata;
                    if (hit) begin
                        r_d.rdata = way_data[hit_way][look_off*BYTE_W +: BYTE_W];
                        lru_we    = 1'b1;
                        lru_val   = ~hit_way;
                        if (cpu_we) begin
                            wr_en[hit_way] = 1'b1;
                            wr_data        = merge_byte(way_data[hit_way], look_off, cpu_wdata);
                            wr_dirty       = 1'b1;
                            r_d.rdata      = cpu_wdata;
                        end
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.victim = victim;
                        r_d.state  = (way_valid[victim] && way_dirty[victim]) ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: if (mem_ack) r_d.state = ST_FILL;
            ST_FILL: begin
                if (mem_ack) begin
                    wr_en[r_q.victim] = 1'b1;
                    wr_data  = r_q.we ? merge_byte(mem_rdata, look_off, r_q.wdata) : mem_rdata;
                    wr_dirty = r_q.we;
                    lru_we   = 1'b1;
                    lru_val  = ~r_q.victim;
                    r_d.rdata = wr_data[look_off*BYTE_W +: BYTE_W];
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q   <= '{state: ST_IDLE, default: '0};
            lru_q <= '0;
        end else begin
            r_q <= r_d;
            if (lru_we) lru_q[look_set] <= lru_val;
        end
    end

    assign cpu_done  = (r_q.state == ST_DONE);
    assign cpu_rdata = r_q.rdata;
    assign mem_req   = (r_q.state == ST_WBACK) || (r_q.state == ST_FILL);
    assign mem_we    = (r_q.state == ST_WBACK);
    assign mem_addr  = mem_we ? {way_tag[r_q.victim], look_set} : r_q.addr[ADDR_W-1:OFF_W];
    assign mem_wdata = way_data[r_q.victim];

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R3
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> cpu_done);

    // R8
    wback_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R2
    no_mem_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !mem_req);
endmodule

// File: tb/tb_wsa_cache.sv
module tb_wsa_cache;
    import wsa_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [BYTE_W-1:0] cpu_wdata = '0;
    logic              cpu_done;
    logic [BYTE_W-1:0] cpu_rdata;
    logic              mem_req, mem_we;
    logic [BLK_W-1:0]  mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    wsa_cache dut (.*);

    int checks = 0, failures = 0;
    int n_rd = 0, n_wr = 0, lat = 0;
    logic [BLK_W-1:0]  last_wb_addr = '0;
    logic [LINE_W-1:0] last_wb_data = '0;
    logic [LINE_W-1:0] store [int];

    function automatic logic [LINE_W-1:0] init_blk(input logic [BLK_W-1:0] b);
        logic [LINE_W-1:0] v;
        for (int k = 0; k < 4; k++) v[k*8 +: 8] = b[7:0] ^ b[20:13] ^ (8'h11 * k[7:0]);
        return v;
    endfunction

    // Behavioural main memory: acknowledges two cycles after a request is seen.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat <= 0;
        end else if (mem_req) begin
            if (lat == 2) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    store[int'(mem_addr)] = mem_wdata;
                    last_wb_addr <= mem_addr;
                    last_wb_data <= mem_wdata;
                    n_wr <= n_wr + 1;
                end else begin
                    mem_rdata <= store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : init_blk(mem_addr);
                    n_rd <= n_rd + 1;
                end
            end else lat <= lat + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic       we;
        logic [8:0] tag;
        logic [12:0] set;
        logic [1:0] off;
        logic [7:0] wd;
        logic [7:0] exp;
        logic [1:0] mrd;
        logic [1:0] mwr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 9'd1, 13'd5, 2'd0, 8'h00, 8'h04, 2'd1, 2'd0},
        '{1'b0, 9'd1, 13'd5, 2'd3, 8'h00, 8'h37, 2'd0, 2'd0},
        '{1'b1, 9'd2, 13'd5, 2'd1, 8'hA5, 8'h00, 2'd1, 2'd0},
        '{1'b0, 9'd2, 13'd5, 2'd1, 8'h00, 8'hA5, 2'd0, 2'd0},
        '{1'b0, 9'd1, 13'd5, 2'd2, 8'h00, 8'h26, 2'd0, 2'd0},
        '{1'b0, 9'd3, 13'd5, 2'd0, 8'h00, 8'h06, 2'd1, 2'd1},
        '{1'b0, 9'd2, 13'd5, 2'd1, 8'h00, 8'hA5, 2'd1, 2'd0},
        '{1'b0, 9'd3, 13'd5, 2'd3, 8'h00, 8'h35, 2'd0, 2'd0},
        '{1'b1, 9'd3, 13'd5, 2'd2, 8'h5A, 8'h00, 2'd0, 2'd0},
        '{1'b0, 9'd1, 13'd5, 2'd1, 8'h00, 8'h15, 2'd1, 2'd0},
        '{1'b0, 9'd4, 13'd5, 2'd0, 8'h00, 8'h01, 2'd1, 2'd1},
        '{1'b0, 9'd3, 13'd5, 2'd2, 8'h00, 8'h5A, 2'd1, 2'd0},
        '{1'b0, 9'd1, 13'd6, 2'd0, 8'h00, 8'h07, 2'd1, 2'd0},
        '{1'b1, 9'd1, 13'd6, 2'd0, 8'h99, 8'h00, 2'd0, 2'd0},
        '{1'b0, 9'd1, 13'd6, 2'd0, 8'h00, 8'h99, 2'd0, 2'd0}
    };

    logic [7:0] got;
    int rd0, wr0;
    bit timed_out = 0;

    task automatic access(input logic we, input logic [8:0] tag, input logic [12:0] set,
                          input logic [1:0] off, input logic [7:0] wd);
        int guard = 0;
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = {tag, set, off}; cpu_wdata = wd;
        do begin
            @(negedge clk);
            guard++;
        end while (!cpu_done && guard < 100);
        if (!cpu_done) timed_out = 1;
        got = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        // R10: completion pulse lasts one cycle
        check(!cpu_done, "R10 done pulse", 32'(cpu_done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        check(!cpu_done && !mem_req, "R9 reset outputs", {30'd0, cpu_done, mem_req}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, VEC[i].tag, VEC[i].set, VEC[i].off, VEC[i].wd);
            // R2 R3 R5 R6 R7: read data
            if (!VEC[i].we) check(got == VEC[i].exp, $sformatf("R2/R3/R7 vec%0d rdata", i), 32'(got), 32'(VEC[i].exp));
            // R3 R4 R5: memory reads
            check((n_rd - rd0) == int'(VEC[i].mrd), $sformatf("R4/R5 vec%0d mem reads", i), 32'(n_rd - rd0), 32'(VEC[i].mrd));
            // R8: write-back only for a dirty victim
            check((n_wr - wr0) == int'(VEC[i].mwr), $sformatf("R8 vec%0d mem writes", i), 32'(n_wr - wr0), 32'(VEC[i].mwr));
            if (i == 5) begin
                // R8 R1: victim block {tag 2, set 5} written back with merged byte
                check(last_wb_addr == {9'd2, 13'd5}, "R8 R1 wb addr", 32'(last_wb_addr), 32'({9'd2, 13'd5}));
                check(last_wb_data == 32'h3425A507, "R8 wb data", last_wb_data, 32'h3425A507);
            end
        end
        // R9: reset discards the dirty byte of set 6 and invalidates all lines
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        access(1'b0, 9'd1, 13'd6, 2'd0, 8'h00);
        check(got == 8'h07, "R9 post-reset rdata", 32'(got), 32'h07);
        check((n_rd - rd0) == 1 && (n_wr - wr0) == 0, "R9 post-reset miss",
              32'((n_rd - rd0) * 16 + (n_wr - wr0)), 32'h10);
        if (timed_out) check(1'b0, "R10 watchdog", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R10 watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule